// File: doc/BRIEF.md
# Modem Handshake Control and Status

This block is the modem handshake part of a serial port controller. Four active-low handshake inputs from the line side are synchronised to the core clock and reported in an 8-bit status word. In that word a low pin reads as a 1. The status word also holds four sticky change flags, one per input line. A 4-bit control register, loaded by a write strobe, drives four active-low outputs: two handshake lines and two general-purpose lines.

A read strobe marks that software has consumed the status word. The change flags are cleared at that clock edge, and a change that is detected at the same edge is still kept. A single interrupt request is raised whenever any change flag is set and the enable input is high. Bus decoding and interrupt prioritisation are left to the surrounding controller.

Top module: `modem_hs_ctrl`

## Requirements
- R1: After reset, `sts_q[3:0]` is 0, all four output pins are high and `irq` is low.
- R2: A `ctl_we` pulse loads `ctl_wdata[3:0]` at the next clock edge. Bit 0 drives `term_ready_n`, bit 1 drives `req_send_n`, bit 2 drives `gp1_n` and bit 3 drives `gp2_n`, and a 1 in a bit drives its pin low. Bits 7:4 of `ctl_wdata` have no effect on any output.
- R3: `sts_q[7:4]` shows the inverted, synchronised level of `clr_send_n` (bit 4), `set_ready_n` (bit 5), `ring_n` (bit 6) and `carrier_n` (bit 7). The value becomes visible two clock edges after the pin changes.
- R4: Any transition of `clr_send_n`, `set_ready_n` or `carrier_n` sets `sts_q[0]`, `sts_q[1]` or `sts_q[3]` respectively, three clock edges after the pin changes.
- R5: `sts_q[2]` is set only when `ring_n` goes from 0 to 1. A 1-to-0 transition of `ring_n` leaves it unchanged.
- R6: The change flags hold until a `sts_re` pulse, which clears `sts_q[3:0]` at that clock edge.
- R7: A change that is detected at the same edge as a `sts_re` pulse sets its flag and is not lost.
- R8: `irq` is high exactly when `irq_en` is high and at least one of `sts_q[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Asynchronous reset, active high |
| clr_send_n | input | 1 | Clear-to-send input, active low |
| set_ready_n | input | 1 | Data-set-ready input, active low |
| ring_n | input | 1 | Ring indicator input, active low |
| carrier_n | input | 1 | Carrier detect input, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; only bits 3:0 are used |
| sts_re | input | 1 | Status read strobe; clears the change flags |
| irq_en | input | 1 | Modem status interrupt enable |
| sts_q | output | 8 | Status word: change flags [3:0], line levels [7:4] |
| term_ready_n | output | 1 | Data-terminal-ready output, active low |
| req_send_n | output | 1 | Request-to-send output, active low |
| gp1_n | output | 1 | General-purpose output 1, active low |
| gp2_n | output | 1 | General-purpose output 2, active low |
| irq | output | 1 | Modem status interrupt request |

## Verification
Inputs are driven and outputs are sampled on the falling clock edge, so each result is checked after a known number of rising edges. The output pins are due one edge after a write. The line levels are due two edges after a pin change. The change flags are due three edges after a pin change, and the flags are checked for absence at two edges as well. A read clears the flags at the edge that samples it, and `irq` follows the flags and the enable combinationally. The same-edge read case is set up by placing the read pulse at the edge where the change is detected.

// File: rtl/modem_hs_ctrl.sv
module modem_hs_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_send_n,
  input  logic       set_ready_n,
  input  logic       ring_n,
  input  logic       carrier_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       sts_re,
  input  logic       irq_en,
  output logic [7:0] sts_q,
  output logic       term_ready_n,
  output logic       req_send_n,
  output logic       gp1_n,
  output logic       gp2_n,
  output logic       irq
);

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] prev_q;
  logic [3:0] delta_q;
  logic [3:0] ctl_q;
  logic [3:0] lvl;
  logic [3:0] diff;
  logic [3:0] evt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 4'hF;
    end else begin
      sync_q[0] <= {carrier_n, ring_n, set_ready_n, clr_send_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl  = sync_q[SYNC_STAGES-1];
  assign diff = lvl ^ prev_q;
  assign evt  = {diff[3], lvl[2] & ~prev_q[2], diff[1], diff[0]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_q  <= 4'hF;
      delta_q <= 4'h0;
      ctl_q   <= 4'h0;
    end else begin
      prev_q  <= lvl;
      delta_q <= (sts_re ? 4'h0 : delta_q) | evt;
      if (ctl_we) ctl_q <= ctl_wdata[3:0];
    end
  end

  assign sts_q        = {~lvl, delta_q};
  assign term_ready_n = ~ctl_q[0];
  assign req_send_n   = ~ctl_q[1];
  assign gp1_n        = ~ctl_q[2];
  assign gp2_n        = ~ctl_q[3];
  assign irq          = irq_en & (|delta_q);

  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> ({gp2_n, gp1_n, req_send_n, term_ready_n} == ~$past(ctl_wdata[3:0])));

  assert_cts_change_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sts_q[4]) |=> sts_q[0]);

  assert_ring_trailing_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sts_q[6]) |=> sts_q[2]);

  assert_ring_leading_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sts_q[6]) && !sts_q[2]) |=> !sts_q[2]);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !sts_re |=> (($past(sts_q[3:0]) & ~sts_q[3:0]) == 4'h0));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (sts_re && lvl == prev_q) |=> sts_q[3:0] == 4'h0);

  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);

endmodule

// File: tb/modem_hs_ctrl_test.sv
module modem_hs_ctrl_test;
  logic clk = 0, rst = 1;
  logic clr_send_n = 1, set_ready_n = 1, ring_n = 1, carrier_n = 1;
  logic ctl_we = 0, sts_re = 0, irq_en = 0;
  logic [7:0] ctl_wdata = 0;
  logic [7:0] sts_q;
  logic term_ready_n, req_send_n, gp1_n, gp2_n, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  modem_hs_ctrl uut (.*);

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pins_out();
    return {gp2_n, gp1_n, req_send_n, term_ready_n};
  endfunction

  task automatic clear_flags();
    sts_re = 1; tick(); sts_re = 0;
  endtask

  task automatic t_reset();
    check("R1 flags", {4'h0, sts_q[3:0]}, 8'h00);
    check("R1 pins", {4'h0, pins_out()}, 8'h0F);
    check("R1 irq", {7'h0, irq}, 8'h00);
  endtask

  task automatic t_control();
    ctl_wdata = 8'hA5; ctl_we = 1; tick(); ctl_we = 0;
    check("R2 pattern 5", {4'h0, pins_out()}, 8'h0A);
    ctl_wdata = 8'hFA; ctl_we = 1; tick(); ctl_we = 0;
    check("R2 pattern A", {4'h0, pins_out()}, 8'h05);
    ctl_wdata = 8'hF0; ctl_we = 1; tick(); ctl_we = 0;
    check("R2 upper bits ignored", {4'h0, pins_out()}, 8'h0F);
  endtask

  task automatic t_levels_cts();
    clr_send_n = 0; carrier_n = 0;
    tick(1);
    check("R3 not yet", {4'h0, sts_q[7:4]}, 8'h00);
    tick(1);
    check("R3 levels", {4'h0, sts_q[7:4]}, 8'h09);
    check("R4 flags not yet", {4'h0, sts_q[3:0]}, 8'h00);
    tick(1);
    check("R4 cts and carrier flags", {4'h0, sts_q[3:0]}, 8'h09);
    tick(3);
    check("R6 flags held", {4'h0, sts_q[3:0]}, 8'h09);
    clear_flags();
    check("R6 read clears", {4'h0, sts_q[3:0]}, 8'h00);
    check("R6 levels kept", {4'h0, sts_q[7:4]}, 8'h09);
    set_ready_n = 0; tick(3);
    check("R4 dsr flag", {4'h0, sts_q[3:0]}, 8'h02);
    clear_flags();
    clr_send_n = 1; tick(3);
    check("R4 cts release flag", {4'h0, sts_q[3:0]}, 8'h01);
    clear_flags();
  endtask

  task automatic t_ring();
    ring_n = 0; tick(4);
    check("R5 leading edge no flag", {4'h0, sts_q[3:0]}, 8'h00);
    check("R3 ring level", {7'h0, sts_q[6]}, 8'h01);
    ring_n = 1; tick(3);
    check("R5 trailing edge flag", {4'h0, sts_q[3:0]}, 8'h04);
    clear_flags();
  endtask

  task automatic t_same_edge();
    clr_send_n = 0; tick(3);
    set_ready_n = 1; tick(2);
    sts_re = 1; tick(); sts_re = 0;
    check("R7 change kept at read", {4'h0, sts_q[3:0]}, 8'h02);
    clear_flags();
  endtask

  task automatic t_irq();
    irq_en = 1; tick();
    check("R8 no flags no irq", {7'h0, irq}, 8'h00);
    carrier_n = 1; tick(3);
    check("R8 irq raised", {7'h0, irq}, 8'h01);
    irq_en = 0; #1;
    check("R8 masked", {7'h0, irq}, 8'h00);
    irq_en = 1; #1;
    check("R8 unmasked", {7'h0, irq}, 8'h01);
    clear_flags();
    check("R8 cleared by read", {7'h0, irq}, 8'h00);
  endtask

  initial begin
    tick(2);
    rst = 0;
    tick();
    t_reset();
    t_control();
    t_levels_cts();
    t_ring();
    t_same_edge();
    t_irq();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule